// File: doc/BRIEF.md
# Complement-Remainder Multiplier

This block multiplies two unsigned N-bit operands into a 2N-bit product. It needs only one (N−1)×(N−1)-bit core multiplication to do so. Each operand is measured against the base 2^(N−1). An operand whose top bit is set has a positive distance above the base, which is its low N−1 bits. An operand whose top bit is clear has a negative distance below the base. That distance is found by two's-complementing its low N−1 bits. The two distances are multiplied together. The product is then assembled from three terms, each added or subtracted according to the top bits of the operands:

- the multiplicand shifted up by N−1 positions;
- the distance of B shifted up by N−1 positions;
- the distance product.

The block suits datapaths that want a narrower core multiplier than the operand width. The core is either a behavioural multiply or a shift-and-add array, chosen by a parameter. The STAGES parameter sets the latency to zero, one or two clock cycles. A valid flag travels alongside the data with the same latency. A zero operand would need a distance of exactly 2^(N−1), which does not fit in N−1 bits. That case is detected, and the product is forced to zero.

Top module: `crm_mul`

## Requirements
- R1: For every pair of unsigned operands, p equals a·b exactly, with either core style.
- R2: When bit N−1 of both a and b is 1, the distance of each operand is its low N−1 bits, and the distance product is added.
- R3: When bit N−1 of both operands is 0 and neither operand is zero, each distance is 2^(N−1) minus the operand, held in N−1 bits, and the distance product is added.
- R4: When the two operands differ in bit N−1 and neither is zero, the distance product is subtracted. The running sum never goes negative and never exceeds 2N bits.
- R5: If a or b is zero, p is zero.
- R6: p and valid_out follow a, b and valid_in by exactly STAGES rising clock edges (STAGES is 0, 1 or 2).
- R7: While rst_n is low, and on the first edges after its release before new data has reached the output, valid_out is 0 and p is 0.
- R8: R1 holds at operand widths of 16 and 32 bits, including the operands 0, 1, 2^(N−1)−1, 2^(N−1) and 2^N−1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Marks a and b as carrying an operation |
| a | input | N | Multiplicand, unsigned |
| b | input | N | Multiplier, unsigned |
| valid_out | output | 1 | valid_in delayed by STAGES cycles |
| p | output | 2N | Unsigned product |

## Verification
The clocked assertions assume that a, b and valid_in are two-valued and change only between rising edges. The pipeline assertions compare against past operands only after enough edges have elapsed since reset. The bench meets these assumptions by driving every input at the falling edge and releasing reset together with the first operand pair. It holds the operands at zero during reset, so the zero-latency variant also shows a zero product then. Zero operands occur naturally in the exhaustive sweep and in the corner list, so the forced-zero path is always reached with legal, known inputs.

// File: rtl/crm_pkg.sv
package crm_pkg;

  // How the distance product enters the sum; MODE_ZERO overrides everything.
  typedef enum logic [1:0] {
    MODE_POS  = 2'd0,
    MODE_NEG  = 2'd1,
    MODE_MIX  = 2'd2,
    MODE_ZERO = 2'd3
  } crm_mode_e;

  function automatic crm_mode_e pick_mode(input logic hi_a, input logic hi_b,
                                          input logic zero_a, input logic zero_b);
    if (zero_a || zero_b) return MODE_ZERO;
    if (hi_a && hi_b)     return MODE_POS;
    if (!hi_a && !hi_b)   return MODE_NEG;
    return MODE_MIX;
  endfunction

  // Product of distances is subtracted only when the signs disagree.
  function automatic logic prod_term_negative(input crm_mode_e m);
    return (m == MODE_MIX);
  endfunction

endpackage

// File: rtl/crm_operand_fold.sv
module crm_operand_fold #(
  parameter int N = 8
) (
  input  logic [N-1:0] x,
  output logic [N-2:0] rem,
  output logic         hi,
  output logic         is_zero
);
  localparam int RW = N - 1;

  // Two's-complement distance below the base, kept in RW bits.
  function automatic logic [RW-1:0] distance_below(input logic [RW-1:0] low);
    return (~low) + {{(RW-1){1'b0}}, 1'b1};
  endfunction

  assign hi      = x[N-1];
  assign is_zero = (x == '0);
  assign rem     = hi ? x[RW-1:0] : distance_below(x[RW-1:0]);

endmodule

// File: rtl/crm_core_mul.sv
module crm_core_mul #(
  parameter int W     = 7,
  parameter bit ARRAY = 1'b0
) (
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;

  generate
    if (ARRAY) begin : g_array
      logic [PW-1:0] rows [W];
      logic [PW-1:0] sum;
      for (genvar i = 0; i < W; i++) begin : g_row
        assign rows[i] = y[i] ? ({{W{1'b0}}, x} << i) : '0;
      end
      always_comb begin
        sum = '0;
        for (int i = 0; i < W; i++) sum = sum + rows[i];
      end
      assign prod = sum;
    end else begin : g_behav
      assign prod = {{W{1'b0}}, x} * {{W{1'b0}}, y};
    end
  endgenerate

endmodule

// File: rtl/crm_combine.sv
module crm_combine import crm_pkg::*; #(
  parameter int N = 8
) (
  input  logic [N-1:0]   mcand,
  input  logic [N-2:0]   rem_b,
  input  logic [2*N-3:0] rprod,
  input  logic           hi_b,
  input  crm_mode_e      mode,
  output logic [2*N-1:0] p,
  output logic           underflow
);
  localparam int W = 2 * N + 1;

  function automatic logic [W-1:0] signed_term(input logic [W-1:0] v, input logic neg);
    return neg ? (~v + {{(W-1){1'b0}}, 1'b1}) : v;
  endfunction

  logic [W-1:0] t_mcand, t_brem, t_rprod, acc;

  always_comb begin
    t_mcand = {{(N+1){1'b0}}, mcand} << (N-1);
    t_brem  = {{(N+2){1'b0}}, rem_b} << (N-1);
    t_rprod = {3'b000, rprod};
    acc = t_mcand
        + signed_term(t_brem, !hi_b)
        + signed_term(t_rprod, prod_term_negative(mode));
  end

  assign underflow = (mode != MODE_ZERO) && acc[W-1];
  assign p         = (mode == MODE_ZERO) ? '0 : acc[2*N-1:0];

endmodule

// File: rtl/crm_mul.sv
module crm_mul import crm_pkg::*; #(
  parameter int N          = 8,
  parameter int STAGES     = 2,
  parameter bit CORE_ARRAY = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           valid_in,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic           valid_out,
  output logic [2*N-1:0] p
);
  localparam int RW = N - 1;
  localparam int PW = 2 * RW;
  localparam logic [N-1:0] BASE = {1'b1, {RW{1'b0}}};

  function automatic logic [2*N-1:0] wide_mul(input logic [N-1:0] x, input logic [N-1:0] y);
    return {{N{1'b0}}, x} * {{N{1'b0}}, y};
  endfunction

  // Front end: distances, mode and core product
  logic [RW-1:0] rem_a, rem_b;
  logic          hi_a, hi_b, zero_a, zero_b;
  logic [PW-1:0] rprod;
  crm_mode_e     f_mode;

  crm_operand_fold #(.N(N)) u_fold_a (.x(a), .rem(rem_a), .hi(hi_a), .is_zero(zero_a));
  crm_operand_fold #(.N(N)) u_fold_b (.x(b), .rem(rem_b), .hi(hi_b), .is_zero(zero_b));

  assign f_mode = pick_mode(hi_a, hi_b, zero_a, zero_b);

  crm_core_mul #(.W(RW), .ARRAY(CORE_ARRAY)) u_core (.x(rem_a), .y(rem_b), .prod(rprod));

  // Optional register between front end and combiner
  logic [N-1:0]  c_mcand;
  logic [RW-1:0] c_remb;
  logic [PW-1:0] c_rprod;
  logic          c_hib, c_valid;
  crm_mode_e     c_mode;

  generate
    if (STAGES >= 2) begin : g_mid_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          c_mcand <= '0;
          c_remb  <= '0;
          c_rprod <= '0;
          c_hib   <= 1'b0;
          c_mode  <= MODE_ZERO;
          c_valid <= 1'b0;
        end else begin
          c_mcand <= a;
          c_remb  <= rem_b;
          c_rprod <= rprod;
          c_hib   <= hi_b;
          c_mode  <= f_mode;
          c_valid <= valid_in;
        end
      end
    end else begin : g_mid_pass
      assign c_mcand = a;
      assign c_remb  = rem_b;
      assign c_rprod = rprod;
      assign c_hib   = hi_b;
      assign c_mode  = f_mode;
      assign c_valid = valid_in;
    end
  endgenerate

  // Back end: signed three-term sum
  logic [2*N-1:0] p_comb;
  logic           underflow;

  crm_combine #(.N(N)) u_comb (
    .mcand(c_mcand), .rem_b(c_remb), .rprod(c_rprod), .hi_b(c_hib),
    .mode(c_mode), .p(p_comb), .underflow(underflow)
  );

  generate
    if (STAGES >= 1) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          p         <= '0;
          valid_out <= 1'b0;
        end else begin
          p         <= p_comb;
          valid_out <= c_valid;
        end
      end
    end else begin : g_out_pass
      assign p         = p_comb;
      assign valid_out = c_valid;
    end
  endgenerate

  // Edges since reset, saturating; lets pipeline checks skip the fill.
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               warm <= 2'd0;
    else if (warm != 2'd3)    warm <= warm + 2'd1;
  end

  // R3: a negative distance plus the low bits of a reach the base exactly.
  assert_neg_distance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!a[N-1] && a != '0) |-> (({1'b0, rem_a} + {1'b0, a[RW-1:0]}) == BASE));

  // R2: the both-positive mode is only chosen for operands at or above the base.
  assert_pos_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (f_mode == MODE_POS) |-> (a >= BASE && b >= BASE));

  // R4: the signed accumulation never drops below zero.
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !underflow);

  // R5: a zero operand reaching the combiner yields a zero sum.
  assert_zero_forces_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (c_mode == MODE_ZERO) |-> (p_comb == '0));

  generate
    if (STAGES == 0) begin : g_chk0
      assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'(STAGES)) |-> (p == wide_mul(a, b)));
    end else if (STAGES == 1) begin : g_chk1
      assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd1) |-> (p == $past(wide_mul(a, b))));
      assert_valid_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd1) |-> (valid_out == $past(valid_in)));
      assert_reset_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd0) |-> (!valid_out && p == '0));
    end else begin : g_chk2
      assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd2) |-> (p == $past(wide_mul(a, b), 2)));
      assert_valid_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd2) |-> (valid_out == $past(valid_in, 2)));
      assert_reset_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd0) |-> (!valid_out && p == '0));
    end
  endgenerate

endmodule

// File: tb/tb_crm_mul.sv
`timescale 1ns/1ps
module tb_crm_mul;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_in = 1'b0;
  always #2 clk = ~clk;

  logic [3:0]  a4 = '0, b4 = '0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [15:0] a16 = '0, b16 = '0;
  logic [31:0] a32 = '0, b32 = '0;
  logic [7:0]  p4;
  logic [15:0] p8;
  logic [31:0] p16;
  logic [63:0] p32;
  logic        v4, v8, v16, v32;

  crm_mul #(.N(4),  .STAGES(0), .CORE_ARRAY(1'b0)) dut4 (.clk(clk), .rst_n(rst_n),
    .valid_in(valid_in), .a(a4), .b(b4), .valid_out(v4), .p(p4));
  crm_mul #(.N(8),  .STAGES(2), .CORE_ARRAY(1'b1)) dut (.clk(clk), .rst_n(rst_n),
    .valid_in(valid_in), .a(a8), .b(b8), .valid_out(v8), .p(p8));
  crm_mul #(.N(16), .STAGES(1), .CORE_ARRAY(1'b1)) dut16 (.clk(clk), .rst_n(rst_n),
    .valid_in(valid_in), .a(a16), .b(b16), .valid_out(v16), .p(p16));
  crm_mul #(.N(32), .STAGES(2), .CORE_ARRAY(1'b0)) dut32 (.clk(clk), .rst_n(rst_n),
    .valid_in(valid_in), .a(a32), .b(b32), .valid_out(v32), .p(p32));

  typedef struct {
    logic        v;
    logic [63:0] p;
    logic [31:0] a;
    logic [31:0] b;
    logic        rst;
  } exp_t;

  // Delay line of expected results per instance: 0=N4, 1=N8, 2=N16, 3=N32.
  exp_t hist [4][3];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  localparam int WIDTHS [4] = '{4, 8, 16, 32};
  localparam int LATS   [4] = '{0, 2, 1, 2};

  function automatic exp_t make_exp(input logic [31:0] x, input logic [31:0] y, input logic v);
    exp_t e;
    e.a = x;
    e.b = y;
    e.v = v;
    e.p = {32'b0, x} * {32'b0, y};
    e.rst = 1'b0;
    return e;
  endfunction

  function automatic string tag_of(input exp_t e, input int n);
    logic ha, hb;
    ha = e.a[n-1];
    hb = e.b[n-1];
    if (e.rst)                  return "R7";
    if (e.a == 0 || e.b == 0)   return "R5";
    if (n >= 16)                return "R8";
    if (ha && hb)               return "R2";
    if (!ha && !hb)             return "R3";
    return "R4";
  endfunction

  function automatic logic [31:0] corner(input int n, input int k);
    longint unsigned one = 1;
    case (k)
      0: return 32'd0;
      1: return 32'd1;
      2: return 32'((one << (n-1)) - 1);
      3: return 32'(one << (n-1));
      default: return 32'((one << n) - 1);
    endcase
  endfunction

  task automatic score(input int idx, input logic [63:0] got_p, input logic got_v);
    exp_t  e;
    string tag;
    e   = hist[idx][LATS[idx]];
    tag = tag_of(e, WIDTHS[idx]);
    checks++;
    if (got_p !== e.p) begin
      fails++;
      $display("FAIL R1 %s N=%0d a=%0h b=%0h p actual=%0h expected=%0h",
               tag, WIDTHS[idx], e.a, e.b, got_p, e.p);
    end
    checks++;
    if (got_v !== e.v) begin
      fails++;
      $display("FAIL R6 %s N=%0d valid_out actual=%0b expected=%0b",
               tag, WIDTHS[idx], got_v, e.v);
    end
  endtask

  task automatic score_all();
    score(0, 64'(p4), v4);
    score(1, 64'(p8), v8);
    score(2, 64'(p16), v16);
    score(3, p32, v32);
  endtask

  task automatic run_vec(input logic [3:0] na4, input logic [3:0] nb4,
                         input logic [7:0] na8, input logic [7:0] nb8,
                         input logic [15:0] na16, input logic [15:0] nb16,
                         input logic [31:0] na32, input logic [31:0] nb32,
                         input logic nv);
    @(negedge clk);
    rst_n = 1'b1;
    a4 = na4;   b4 = nb4;
    a8 = na8;   b8 = nb8;
    a16 = na16; b16 = nb16;
    a32 = na32; b32 = nb32;
    valid_in = nv;
    for (int i = 0; i < 4; i++) begin
      hist[i][2] = hist[i][1];
      hist[i][1] = hist[i][0];
    end
    hist[0][0] = make_exp({28'b0, na4}, {28'b0, nb4}, nv);
    hist[1][0] = make_exp({24'b0, na8}, {24'b0, nb8}, nv);
    hist[2][0] = make_exp({16'b0, na16}, {16'b0, nb16}, nv);
    hist[3][0] = make_exp(na32, nb32, nv);
    #1;
    score_all();
  endtask

  initial begin
    for (int i = 0; i < 4; i++)
      for (int k = 0; k < 3; k++) begin
        hist[i][k].v = 1'b0;
        hist[i][k].p = '0;
        hist[i][k].a = '0;
        hist[i][k].b = '0;
        hist[i][k].rst = 1'b1;
      end

    // R7: outputs held at zero while reset is asserted
    repeat (3) begin
      @(negedge clk);
      #1;
      score_all();
    end

    // R1 R2 R3 R4 R5: exhaustive for N=8 (and N=4 on the low nibbles)
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++)
        run_vec(4'(i), 4'(j), 8'(i), 8'(j),
                16'($urandom), 16'($urandom), $urandom, $urandom,
                ($urandom % 4) != 0);

    // R8: corner operands at every width
    for (int ci = 0; ci < 5; ci++)
      for (int cj = 0; cj < 5; cj++)
        run_vec(4'(corner(4, ci)), 4'(corner(4, cj)),
                8'(corner(8, ci)), 8'(corner(8, cj)),
                16'(corner(16, ci)), 16'(corner(16, cj)),
                corner(32, ci), corner(32, cj), ((ci + cj) % 2) == 0);

    // R8: random wide operands, R6 with a scattered valid pattern
    for (int r = 0; r < 2000; r++)
      run_vec(4'($urandom), 4'($urandom), 8'($urandom), 8'($urandom),
              16'($urandom), 16'($urandom), $urandom, $urandom,
              ($urandom % 3) == 0);

    // Flush the deepest pipeline
    repeat (3) run_vec('0, '0, '0, '0, '0, '0, '0, '0, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule